// File: doc/BRIEF.md
# Age-Ordered Completion Arbiter

This block sits where the execute pipes of a superscalar core hand back finished work. Each of `N_PIPES` pipes may present one completed result, tagged with its sequence number. Each cycle the arbiter picks the oldest of those requests and places them on up to `M_LANES` output lanes. Downstream capacity is given as a count of free slots and a full flag. The pipes that win see their ready bit in the same cycle, so they can retire the request on that edge.

Age is measured as the distance from the oldest not-yet-committed sequence number, modulo the sequence space. This keeps the ordering correct when the counter wraps. Matching runs as a chain of grant/accept passes, one per output lane. In each pass every enabled lane grants to the oldest pipe that is still unmatched, and that pipe accepts the lowest such lane. The winners come out packed from lane 0 upward in age order and are registered one cycle later.

Top module: `age_compl_arb`

## Requirements
- R1: The lane budget is the smaller of `free_slots` and `M_LANES`, and is zero while `fifo_full` is high. The number of ready bits never exceeds it.
- R2: The number of granted pipes in a cycle equals min(budget, number of valid requests).
- R3: The granted pipes are the oldest valid ones. Age = (`req_seq` − `oldest_seq`) mod 2^`SEQ_W`, and a smaller age is older. Equal ages go to the lower pipe index.
- R4: Output lane k carries the k-th oldest granted request (lane 0 the oldest). Valid lanes form a contiguous run starting at lane 0, and lanes past the grant count are invalid.
- R5: `req_ready[i]` is high in the same cycle exactly when pipe i is granted.
- R6: Lane outputs (`lane_valid`, `lane_pipe`, `lane_seq`, `lane_data`) are registered: they show the result of the inputs at the previous rising edge. Synchronous reset clears `lane_valid`.
- R7: A pipe whose `req_valid` bit is low is never granted, whatever its sequence number.
- R8: A sequence number numerically below `oldest_seq` counts as younger than every number at or above it, because it has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_PIPES | Completion request per pipe |
| req_seq | input | N_PIPES*SEQ_W | Sequence number per pipe, pipe i at bits [i*SEQ_W +: SEQ_W] |
| req_data | input | N_PIPES*DATA_W | Payload per pipe, pipe i at bits [i*DATA_W +: DATA_W] |
| oldest_seq | input | SEQ_W | Oldest uncommitted sequence number (age origin) |
| free_slots | input | FREE_W | Free downstream slots |
| fifo_full | input | 1 | Downstream buffer full; forces a zero budget |
| req_ready | output | N_PIPES | Grant back to each pipe, same cycle |
| lane_valid | output | M_LANES | Registered lane valid bits |
| lane_pipe | output | M_LANES*PIPE_W | Registered source pipe index per lane |
| lane_seq | output | M_LANES*SEQ_W | Registered sequence number per lane |
| lane_data | output | M_LANES*DATA_W | Registered payload per lane |

## Verification
Two limits on the grant count can apply in the same cycle: the budget and the number of valid requests. Cycles are driven where each one is the tighter limit, and where both are equal. The sequence-wrap ordering and the tie-break also meet in one cycle, when two pipes carry equal wrapped ages while other pipes hold unwrapped numbers. Every cycle is compared against a sort on the key age·N + index, for both the ready pattern and the lane contents one cycle later.

// File: rtl/age_arb_pkg.sv
package age_arb_pkg;

  // Index of the single set bit of a one-hot word (0 when empty).
  function automatic int unsigned oh_index(input logic [31:0] oh);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (oh[i]) idx = idx | i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/age_rel.sv
module age_rel #(
  parameter int N_PIPES = 6,
  parameter int SEQ_W   = 6
) (
  input  logic [N_PIPES*SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]         origin,
  output logic [N_PIPES*SEQ_W-1:0] age
);
  // Distance from the commit origin, modulo the sequence space.
  for (genvar i = 0; i < N_PIPES; i++) begin : g_age
    assign age[i*SEQ_W +: SEQ_W] = seq[i*SEQ_W +: SEQ_W] - origin;
  end
endmodule

// File: rtl/oldest_pick.sv
module oldest_pick #(
  parameter int N_PIPES = 6,
  parameter int SEQ_W   = 6
) (
  input  logic [N_PIPES-1:0]       cand,
  input  logic [N_PIPES*SEQ_W-1:0] age,
  output logic [N_PIPES-1:0]       pick
);
  logic [SEQ_W-1:0] best_age;
  logic             found;

  // Strict compare keeps the lower index on equal age.
  always_comb begin
    pick     = '0;
    best_age = '0;
    found    = 1'b0;
    for (int i = 0; i < N_PIPES; i++) begin
      if (cand[i] && (!found || age[i*SEQ_W +: SEQ_W] < best_age)) begin
        pick     = '0;
        pick[i]  = 1'b1;
        best_age = age[i*SEQ_W +: SEQ_W];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_match.sv
module lane_match #(
  parameter int N_PIPES = 6,
  parameter int SEQ_W   = 6
) (
  input  logic [N_PIPES-1:0]       unmatched,
  input  logic                     lane_en,
  input  logic [N_PIPES*SEQ_W-1:0] age,
  output logic [N_PIPES-1:0]       win,
  output logic [N_PIPES-1:0]       left
);
  logic [N_PIPES-1:0] grant;

  // Grant phase: every still-enabled lane grants to the same oldest pipe.
  oldest_pick #(.N_PIPES(N_PIPES), .SEQ_W(SEQ_W)) u_pick (
    .cand (unmatched),
    .age  (age),
    .pick (grant)
  );

  // Accept phase: the pipe takes the lowest granting lane, which is this one.
  assign win  = lane_en ? grant : '0;
  assign left = unmatched & ~win;
endmodule

// File: rtl/age_compl_arb.sv
module age_compl_arb
  import age_arb_pkg::*;
#(
  parameter int N_PIPES = 6,
  parameter int M_LANES = 3,
  parameter int SEQ_W   = 6,
  parameter int DATA_W  = 16,
  parameter int FREE_W  = 3,
  parameter int PIPE_W  = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PIPES-1:0]        req_valid,
  input  logic [N_PIPES*SEQ_W-1:0]  req_seq,
  input  logic [N_PIPES*DATA_W-1:0] req_data,
  input  logic [SEQ_W-1:0]          oldest_seq,
  input  logic [FREE_W-1:0]         free_slots,
  input  logic                      fifo_full,
  output logic [N_PIPES-1:0]        req_ready,
  output logic [M_LANES-1:0]        lane_valid,
  output logic [M_LANES*PIPE_W-1:0] lane_pipe,
  output logic [M_LANES*SEQ_W-1:0]  lane_seq,
  output logic [M_LANES*DATA_W-1:0] lane_data
);

  logic [N_PIPES*SEQ_W-1:0] age;
  logic [M_LANES-1:0]       lane_en;
  logic [N_PIPES-1:0]       chain [M_LANES+1];
  logic [N_PIPES-1:0]       win   [M_LANES];

  age_rel #(.N_PIPES(N_PIPES), .SEQ_W(SEQ_W)) u_age (
    .seq    (req_seq),
    .origin (oldest_seq),
    .age    (age)
  );

  // Thermometer enable: lane k takes part when k < min(free, M), none when full.
  always_comb begin
    for (int k = 0; k < M_LANES; k++) begin
      lane_en[k] = !fifo_full && (k < int'(free_slots));
    end
  end

  assign chain[0] = req_valid;

  for (genvar k = 0; k < M_LANES; k++) begin : g_lane
    lane_match #(.N_PIPES(N_PIPES), .SEQ_W(SEQ_W)) u_match (
      .unmatched (chain[k]),
      .lane_en   (lane_en[k]),
      .age       (age),
      .win       (win[k]),
      .left      (chain[k+1])
    );
  end

  always_comb begin
    req_ready = '0;
    for (int k = 0; k < M_LANES; k++) req_ready = req_ready | win[k];
  end

  // Pack each lane's winner and register.
  logic [M_LANES-1:0]        nxt_valid;
  logic [M_LANES*PIPE_W-1:0] nxt_pipe;
  logic [M_LANES*SEQ_W-1:0]  nxt_seq;
  logic [M_LANES*DATA_W-1:0] nxt_data;

  always_comb begin
    nxt_valid = '0;
    nxt_pipe  = '0;
    nxt_seq   = '0;
    nxt_data  = '0;
    for (int k = 0; k < M_LANES; k++) begin
      nxt_valid[k] = |win[k];
      nxt_pipe[k*PIPE_W +: PIPE_W] = PIPE_W'(oh_index(32'(win[k])));
      for (int i = 0; i < N_PIPES; i++) begin
        if (win[k][i]) begin
          nxt_seq[k*SEQ_W +: SEQ_W]   = req_seq[i*SEQ_W +: SEQ_W];
          nxt_data[k*DATA_W +: DATA_W] = req_data[i*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_valid <= '0;
      lane_pipe  <= '0;
      lane_seq   <= '0;
      lane_data  <= '0;
    end else begin
      lane_valid <= nxt_valid;
      lane_pipe  <= nxt_pipe;
      lane_seq   <= nxt_seq;
      lane_data  <= nxt_data;
    end
  end

endmodule

// File: rtl/age_compl_arb_chk.sv
module age_compl_arb_chk #(
  parameter int N_PIPES = 6,
  parameter int M_LANES = 3,
  parameter int FREE_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PIPES-1:0] req_valid,
  input logic [FREE_W-1:0]  free_slots,
  input logic               fifo_full,
  input logic [N_PIPES-1:0] req_ready,
  input logic [M_LANES-1:0] lane_valid
);
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0); // R7
  AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> req_ready == '0); // R1
  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
    $countones(req_ready) <= int'(free_slots)); // R1
  AST_GRANT_CAP: assert property (@(posedge clk) disable iff (rst)
    $countones(req_ready) <= M_LANES); // R2
  AST_LANE_PACKED: assert property (@(posedge clk) disable iff (rst)
    (lane_valid & (lane_valid + M_LANES'(1))) == '0); // R4
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(lane_valid) == $past($countones(req_ready))); // R6
endmodule

bind age_compl_arb age_compl_arb_chk #(
  .N_PIPES(N_PIPES), .M_LANES(M_LANES), .FREE_W(FREE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .free_slots(free_slots),
  .fifo_full(fifo_full), .req_ready(req_ready), .lane_valid(lane_valid)
);

// File: tb/age_compl_arb_test.sv
module age_compl_arb_test;
  localparam int N = 6, M = 3, SW = 6, DW = 16, FW = 3, PW = 3;

  logic clk = 0, rst = 1;
  logic [N-1:0]    req_valid = '0;
  logic [N*SW-1:0] req_seq = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [SW-1:0]   oldest_seq = '0;
  logic [FW-1:0]   free_slots = '0;
  logic            fifo_full = 0;
  logic [N-1:0]    req_ready;
  logic [M-1:0]    lane_valid;
  logic [M*PW-1:0] lane_pipe;
  logic [M*SW-1:0] lane_seq;
  logic [M*DW-1:0] lane_data;

  age_compl_arb #(.N_PIPES(N), .M_LANES(M), .SEQ_W(SW), .DATA_W(DW), .FREE_W(FW)) uut (
    .clk, .rst, .req_valid, .req_seq, .req_data, .oldest_seq, .free_slots,
    .fifo_full, .req_ready, .lane_valid, .lane_pipe, .lane_seq, .lane_data);

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  int exp_pipe[M];
  int exp_n = 0;
  logic [N-1:0] exp_ready;

  // Reference: repeated minimum over key = age*N + index.
  task automatic model(output int pipes[M], output int n, output logic [N-1:0] rdy);
    int budget, taken[N];
    budget = fifo_full ? 0 : ((int'(free_slots) < M) ? int'(free_slots) : M);
    for (int i = 0; i < N; i++) taken[i] = 0;
    rdy = '0; n = 0;
    for (int k = 0; k < M; k++) pipes[k] = -1;
    for (int k = 0; k < budget; k++) begin
      int best, bkey;
      best = -1; bkey = 1 << 30;
      for (int i = 0; i < N; i++) begin
        int key;
        key = (int'(req_seq[i*SW +: SW] - oldest_seq) & 63) * N + i;
        if (req_valid[i] && !taken[i] && key < bkey) begin bkey = key; best = i; end
      end
      if (best >= 0) begin taken[best] = 1; pipes[k] = best; rdy[best] = 1; n++; end
    end
  endtask

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at negedge: check registered lanes from last cycle, then ready now.
  task automatic check(string tag);
    int p[M], n;
    logic [N-1:0] r;
    for (int k = 0; k < M; k++) begin
      cmp({tag, "/R4 lane_valid"}, int'(lane_valid[k]), (exp_pipe[k] >= 0) ? 1 : 0);
      if (exp_pipe[k] >= 0) begin
        cmp({tag, "/R4 lane_pipe"}, int'(lane_pipe[k*PW +: PW]), exp_pipe[k]);
        cmp({tag, "/R6 lane_seq"}, int'(lane_seq[k*SW +: SW]), int'(req_seq_prev[exp_pipe[k]]));
        cmp({tag, "/R6 lane_data"}, int'(lane_data[k*DW +: DW]), int'(req_data_prev[exp_pipe[k]]));
      end
    end
    model(p, n, r);
    cmp({tag, "/R5 ready"}, int'(req_ready), int'(r));
    cmp({tag, "/R2 count"}, $countones(req_ready), n);
    exp_pipe = p; exp_n = n; exp_ready = r;
    for (int i = 0; i < N; i++) begin
      req_seq_prev[i]  = req_seq[i*SW +: SW];
      req_data_prev[i] = req_data[i*DW +: DW];
    end
  endtask

  logic [SW-1:0] req_seq_prev[N];
  logic [DW-1:0] req_data_prev[N];

  task automatic step(string tag, logic [N-1:0] v, logic [N*SW-1:0] s,
                      logic [SW-1:0] o, logic [FW-1:0] f, logic full);
    @(posedge clk); #2;
    req_valid = v; req_seq = s; oldest_seq = o; free_slots = f; fifo_full = full;
    for (int i = 0; i < N; i++) req_data[i*DW +: DW] = DW'($urandom);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [N*SW-1:0] pack(int a, int b, int c, int d, int e, int g);
    return {SW'(g), SW'(e), SW'(d), SW'(c), SW'(b), SW'(a)};
  endfunction

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog R2 actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < M; k++) exp_pipe[k] = -1;
    for (int i = 0; i < N; i++) begin req_seq_prev[i] = '0; req_data_prev[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R6 reset lane_valid", int'(lane_valid), 0);
    #2 rst = 0;
    // R3: plain age order, budget limits
    step("R3", 6'b111111, pack(5, 3, 9, 1, 7, 2), 0, 7, 0);
    // R1: full flag zeros the budget
    step("R1", 6'b111111, pack(5, 3, 9, 1, 7, 2), 0, 7, 1);
    // R1: free slots below M
    step("R1", 6'b111111, pack(5, 3, 9, 1, 7, 2), 0, 2, 0);
    step("R1", 6'b111111, pack(5, 3, 9, 1, 7, 2), 0, 0, 0);
    // R2: fewer valid than budget
    step("R2", 6'b010010, pack(5, 3, 9, 1, 7, 2), 0, 3, 0);
    // R2: valid count equals budget
    step("R2", 6'b100101, pack(5, 3, 9, 1, 7, 2), 0, 3, 0);
    // R7: invalid pipes with the oldest numbers are skipped
    step("R7", 6'b110000, pack(1, 1, 2, 2, 40, 30), 0, 7, 0);
    // R8: wrapped numbers are younger than those past the origin
    step("R8", 6'b111111, pack(2, 62, 60, 1, 61, 0), 60, 7, 0);
    // R3 tie + R8 wrap in the same cycle
    step("R3", 6'b111111, pack(3, 58, 3, 3, 63, 50), 55, 7, 0);
    step("R4", 6'b000000, pack(0, 0, 0, 0, 0, 0), 0, 7, 0);
    for (int t = 0; t < 400; t++) begin
      logic [N*SW-1:0] s;
      for (int i = 0; i < N; i++) s[i*SW +: SW] = SW'($urandom_range(0, 63));
      step("R3", N'($urandom), s, SW'($urandom), FW'($urandom), ($urandom_range(0, 7) == 0));
    end
    step("R6", 6'b000000, pack(0, 0, 0, 0, 0, 0), 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule